// File: doc/BRIEF.md
# Trim Store Parity Monitor with Response Gating

This block models a 128-bit one-time-programmable trim store. The low 48 bits form the factory region. They are loaded from a parameter image at reset and are never written afterwards. The high 80 bits form the customer region. That region starts out blank and can be programmed one bit at a time. Each region carries its own even-parity bit. Both parity checks are evaluated from the live store contents on every cycle, not only after start-up.

Customer programming can arrive from two request ports: a bus command port and a serial test/trim port. Each request names one bit address and a value. Storage cells can only go from 0 to 1. Requests that break the programming rules are dropped and raise a sticky error flag. The bus port has priority over the serial port.

A read-acceleration request passes the converter sample to a registered response. If either region shows a parity fault, the response is zero instead. Zero is reserved for the fault case, so a genuine zero sample is sent as one.

Top module: `otp_parity_gate`

## Requirements
- R1: After synchronous reset, trim_word[47:0] equals the factory image parameter and trim_word[127:48] is all zero. prog_err, rsp_vld and both parity flags are low when the factory image has even parity.
- R2: fact_par_err is high exactly when trim_word[47:0] has an odd number of ones (bit 47 is the factory parity bit). cust_par_err is high exactly when trim_word[127:48] has an odd number of ones (bit 127 is the customer parity bit). Both follow the store in the same cycle it changes.
- R3: A granted request with an address in 48..127 and value 1 sets that bit at the next clock edge. A request with value 0 aimed at a bit that is still 0 changes nothing and raises no error.
- R4: A request with value 0 aimed at a bit that is already 1 is ignored, and prog_err is set.
- R5: A request with an address in 0..47 (factory region) is ignored, and prog_err is set.
- R6: Bit 126 is the customer lock bit, and locked shows its value. While it is 1, every request from either port is ignored and sets prog_err.
- R7: ser_grant is high exactly when ser_prog_vld is high and bus_prog_vld is low. When both ports request in the same cycle, only the bus request is applied, and the serial source keeps its request for a following cycle.
- R8: rd_req in one cycle gives rsp_vld high for one cycle on the next cycle. rsp_data is zero if either parity flag was high in the request cycle, and the sample otherwise.
- R9: A sample of zero with no parity fault is returned as one.
- R10: prog_err stays high until reset once it has been set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_prog_vld | input | 1 | Bus command program request |
| bus_prog_addr | input | 7 | Bus request bit address |
| bus_prog_val | input | 1 | Bus request bit value |
| ser_prog_vld | input | 1 | Serial test/trim program request |
| ser_prog_addr | input | 7 | Serial request bit address |
| ser_prog_val | input | 1 | Serial request bit value |
| ser_grant | output | 1 | Serial request taken this cycle |
| rd_req | input | 1 | Read-acceleration request |
| adc_sample | input | SAMPLE_W | Converter sample to return |
| rsp_vld | output | 1 | Response valid |
| rsp_data | output | SAMPLE_W | Response value, zero on parity fault |
| trim_word | output | 128 | Full store contents |
| fact_par_err | output | 1 | Factory region parity fault |
| cust_par_err | output | 1 | Customer region parity fault |
| locked | output | 1 | Customer region locked |
| prog_err | output | 1 | Sticky programming rule violation |

## Verification
The checker enforces on every cycle that stored bits never return to 0, that the factory bits never move, that prog_err and the lock stay sticky, that the bus port always blocks the serial grant, and that a read during a fault returns zero while a read without one never does. Whether each specific request should have been applied or rejected, the exact parity of the resulting word, and the remapping of a zero sample can only be judged by the bench's reference model. The bench drives directed cases and constrained-random request mixes against that model.

// File: rtl/otp_pkg.sv
package otp_pkg;
    localparam int OTP_BITS  = 128;
    localparam int CUST_BITS = 80;
    localparam int FACT_BITS = OTP_BITS - CUST_BITS;
    localparam int ADDR_W    = $clog2(OTP_BITS);
    localparam int CUST_LO   = FACT_BITS;
    localparam int LOCK_POS  = OTP_BITS - 2;

    typedef struct packed {
        logic              vld;
        logic [ADDR_W-1:0] addr;
        logic              val;
    } prog_req_t;

    typedef enum logic [1:0] {
        PV_IDLE   = 2'd0,
        PV_NOOP   = 2'd1,
        PV_APPLY  = 2'd2,
        PV_REJECT = 2'd3
    } prog_verdict_t;

    // Decide what a single-bit program request does to the store.
    function automatic prog_verdict_t judge_req(input prog_req_t req,
                                                input logic cur_bit,
                                                input logic is_locked);
        if (!req.vld)
            return PV_IDLE;
        if (is_locked || (req.addr < ADDR_W'(CUST_LO)))
            return PV_REJECT;
        if (!req.val)
            return cur_bit ? PV_REJECT : PV_NOOP;
        return PV_APPLY;
    endfunction
endpackage

// File: rtl/otp_prog_arb.sv
module otp_prog_arb
    import otp_pkg::*;
(
    input  prog_req_t bus_req,
    input  prog_req_t ser_req,
    output prog_req_t win_req,
    output logic      ser_grant
);
    always_comb begin
        ser_grant = ser_req.vld && !bus_req.vld;
        win_req   = bus_req.vld ? bus_req : ser_req;
    end
endmodule

// File: rtl/otp_store.sv
module otp_store
    import otp_pkg::*;
#(
    parameter logic [FACT_BITS-1:0] FACTORY_IMAGE = 48'h0000_0000_00A5
) (
    input  logic                clk,
    input  logic                rst,
    input  prog_req_t           req,
    output logic [OTP_BITS-1:0] image,
    output logic                err
);
    prog_verdict_t verdict;

    always_comb verdict = judge_req(req, image[req.addr], image[LOCK_POS]);

    always_ff @(posedge clk) begin
        if (rst) begin
            image <= {{CUST_BITS{1'b0}}, FACTORY_IMAGE};
            err   <= 1'b0;
        end else begin
            case (verdict)
                PV_APPLY:  image[req.addr] <= 1'b1;
                PV_REJECT: err <= 1'b1;
                default:   ;
            endcase
        end
    end
endmodule

// File: rtl/otp_parity_chk.sv
module otp_parity_chk #(
    parameter int W = 48
) (
    input  logic [W-1:0] bits,
    output logic         fault
);
    // Even parity: data plus parity bit must hold an even count of ones.
    always_comb fault = ^bits;
endmodule

// File: rtl/otp_rsp_gate.sv
module otp_rsp_gate #(
    parameter int SAMPLE_W = 10
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                rd_req,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic                fault,
    output logic                rsp_vld,
    output logic [SAMPLE_W-1:0] rsp_data
);
    logic [SAMPLE_W-1:0] gated;

    always_comb begin
        if (fault)
            gated = '0;
        else if (sample == '0)
            gated = SAMPLE_W'(1);
        else
            gated = sample;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_vld  <= 1'b0;
            rsp_data <= '0;
        end else begin
            rsp_vld  <= rd_req;
            rsp_data <= rd_req ? gated : '0;
        end
    end
endmodule

// File: rtl/otp_parity_gate.sv
module otp_parity_gate
    import otp_pkg::*;
#(
    parameter int                   SAMPLE_W      = 10,
    parameter logic [FACT_BITS-1:0] FACTORY_IMAGE = 48'h0000_0000_00A5
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_prog_vld,
    input  logic [ADDR_W-1:0]   bus_prog_addr,
    input  logic                bus_prog_val,
    input  logic                ser_prog_vld,
    input  logic [ADDR_W-1:0]   ser_prog_addr,
    input  logic                ser_prog_val,
    output logic                ser_grant,
    input  logic                rd_req,
    input  logic [SAMPLE_W-1:0] adc_sample,
    output logic                rsp_vld,
    output logic [SAMPLE_W-1:0] rsp_data,
    output logic [OTP_BITS-1:0] trim_word,
    output logic                fact_par_err,
    output logic                cust_par_err,
    output logic                locked,
    output logic                prog_err
);
    prog_req_t bus_req, ser_req, win_req;

    always_comb begin
        bus_req = '{vld: bus_prog_vld, addr: bus_prog_addr, val: bus_prog_val};
        ser_req = '{vld: ser_prog_vld, addr: ser_prog_addr, val: ser_prog_val};
    end

    otp_prog_arb u_arb (
        .bus_req   (bus_req),
        .ser_req   (ser_req),
        .win_req   (win_req),
        .ser_grant (ser_grant)
    );

    otp_store #(.FACTORY_IMAGE(FACTORY_IMAGE)) u_store (
        .clk   (clk),
        .rst   (rst),
        .req   (win_req),
        .image (trim_word),
        .err   (prog_err)
    );

    otp_parity_chk #(.W(FACT_BITS)) u_fact_par (
        .bits  (trim_word[FACT_BITS-1:0]),
        .fault (fact_par_err)
    );

    otp_parity_chk #(.W(CUST_BITS)) u_cust_par (
        .bits  (trim_word[OTP_BITS-1:CUST_LO]),
        .fault (cust_par_err)
    );

    always_comb locked = trim_word[LOCK_POS];

    otp_rsp_gate #(.SAMPLE_W(SAMPLE_W)) u_rsp (
        .clk      (clk),
        .rst      (rst),
        .rd_req   (rd_req),
        .sample   (adc_sample),
        .fault    (fact_par_err || cust_par_err),
        .rsp_vld  (rsp_vld),
        .rsp_data (rsp_data)
    );
endmodule

// File: rtl/otp_parity_gate_chk.sv
module otp_parity_gate_chk
    import otp_pkg::*;
#(
    parameter int SAMPLE_W = 10
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_prog_vld,
    input logic                ser_prog_vld,
    input logic                ser_grant,
    input logic                rd_req,
    input logic                rsp_vld,
    input logic [SAMPLE_W-1:0] rsp_data,
    input logic [OTP_BITS-1:0] trim_word,
    input logic                fact_par_err,
    input logic                cust_par_err,
    input logic                locked,
    input logic                prog_err
);
    // R3
    bits_only_set_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> ((trim_word & $past(trim_word)) == $past(trim_word)));

    // R5
    factory_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(trim_word[FACT_BITS-1:0]));

    // R6
    lock_holds_store_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(locked)) |-> $stable(trim_word));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(prog_err)) |-> prog_err);

    // R7
    bus_blocks_serial_chk: assert property (@(posedge clk) disable iff (rst)
        bus_prog_vld |-> !ser_grant);

    // R7
    serial_alone_granted_chk: assert property (@(posedge clk) disable iff (rst)
        (ser_prog_vld && !bus_prog_vld) |-> ser_grant);

    // R8
    fault_gives_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && (fact_par_err || cust_par_err)) |=> (rsp_vld && rsp_data == '0));

    // R9
    clean_never_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !fact_par_err && !cust_par_err) |=> (rsp_vld && rsp_data != '0));

    // R8
    rsp_one_shot_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_req |=> !rsp_vld);
endmodule

bind otp_parity_gate otp_parity_gate_chk #(.SAMPLE_W(SAMPLE_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .bus_prog_vld (bus_prog_vld),
    .ser_prog_vld (ser_prog_vld),
    .ser_grant    (ser_grant),
    .rd_req       (rd_req),
    .rsp_vld      (rsp_vld),
    .rsp_data     (rsp_data),
    .trim_word    (trim_word),
    .fact_par_err (fact_par_err),
    .cust_par_err (cust_par_err),
    .locked       (locked),
    .prog_err     (prog_err)
);

// File: tb/otp_parity_gate_test.sv
`timescale 1ns/1ps
module otp_parity_gate_test;
    localparam int SW = 10;
    localparam logic [47:0] GOOD_IMG = 48'h0000_0000_00A5;
    localparam logic [47:0] BAD_IMG  = 48'h0000_0000_00A4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst = 1'b1;
    logic          bus_vld = 0, bus_val = 0, ser_vld = 0, ser_val = 0, rd = 0;
    logic [6:0]    bus_addr = '0, ser_addr = '0;
    logic [SW-1:0] samp = '0;

    logic          ser_grant, rsp_vld, fact_err, cust_err, locked, perr;
    logic [SW-1:0] rsp_data;
    logic [127:0]  trim;
    logic          b_grant, b_rsp_vld, b_fact_err, b_cust_err, b_locked, b_perr;
    logic [SW-1:0] b_rsp_data;
    logic [127:0]  b_trim;

    otp_parity_gate #(.SAMPLE_W(SW), .FACTORY_IMAGE(GOOD_IMG)) uut (
        .clk(clk), .rst(rst),
        .bus_prog_vld(bus_vld), .bus_prog_addr(bus_addr), .bus_prog_val(bus_val),
        .ser_prog_vld(ser_vld), .ser_prog_addr(ser_addr), .ser_prog_val(ser_val),
        .ser_grant(ser_grant), .rd_req(rd), .adc_sample(samp),
        .rsp_vld(rsp_vld), .rsp_data(rsp_data), .trim_word(trim),
        .fact_par_err(fact_err), .cust_par_err(cust_err),
        .locked(locked), .prog_err(perr)
    );

    otp_parity_gate #(.SAMPLE_W(SW), .FACTORY_IMAGE(BAD_IMG)) uut_bad (
        .clk(clk), .rst(rst),
        .bus_prog_vld(bus_vld), .bus_prog_addr(bus_addr), .bus_prog_val(bus_val),
        .ser_prog_vld(ser_vld), .ser_prog_addr(ser_addr), .ser_prog_val(ser_val),
        .ser_grant(b_grant), .rd_req(rd), .adc_sample(samp),
        .rsp_vld(b_rsp_vld), .rsp_data(b_rsp_data), .trim_word(b_trim),
        .fact_par_err(b_fact_err), .cust_par_err(b_cust_err),
        .locked(b_locked), .prog_err(b_perr)
    );

    int total = 0;
    int bad = 0;
    logic [127:0] m;
    logic         merr;

    task automatic chk(input bit ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit odd_ones(input logic [127:0] v, input int lo, input int hi);
        bit p = 0;
        for (int i = lo; i <= hi; i++) p ^= v[i];
        return p;
    endfunction

    task automatic model_req(input bit v, input int a, input bit val);
        if (!v) return;
        if (a < 48 || m[126]) merr = 1'b1;
        else if (!val && m[a]) merr = 1'b1;
        else if (val) m[a] = 1'b1;
    endtask

    task automatic do_reset();
        rst = 1'b1; bus_vld = 0; ser_vld = 0; rd = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        m = {80'b0, GOOD_IMG};
        merr = 1'b0;
        chk(trim == m, "R1 reset image", trim, m);
        chk(perr == 1'b0 && rsp_vld == 1'b0, "R1 reset flags", {perr, rsp_vld}, 0);
        chk(fact_err == 0 && cust_err == 0, "R1 reset parity", {fact_err, cust_err}, 0);
    endtask

    task automatic step(input bit bv, input int ba, input bit bval,
                        input bit sv, input int sa, input bit sval,
                        input bit r, input int s, input string tag);
        bit f;
        logic [SW-1:0] exp_rsp;
        bus_vld = bv; bus_addr = 7'(ba); bus_val = bval;
        ser_vld = sv; ser_addr = 7'(sa); ser_val = sval;
        rd = r; samp = SW'(s);
        #1;
        chk(ser_grant == (sv && !bv), {tag, " R7 grant"}, ser_grant, sv && !bv);
        f = odd_ones(m, 0, 47) || odd_ones(m, 48, 127);
        exp_rsp = f ? '0 : ((s == 0) ? SW'(1) : SW'(s));
        model_req(bv, ba, bval);
        if (sv && !bv) model_req(sv, sa, sval);
        @(posedge clk);
        #1;
        bus_vld = 0; ser_vld = 0; rd = 0;
        chk(trim == m, {tag, " R3 store"}, trim, m);
        chk(perr == merr, {tag, " R4 R10 err"}, perr, merr);
        chk(cust_err == odd_ones(m, 48, 127), {tag, " R2 cust parity"}, cust_err, odd_ones(m, 48, 127));
        chk(fact_err == odd_ones(m, 0, 47), {tag, " R2 fact parity"}, fact_err, odd_ones(m, 0, 47));
        chk(locked == m[126], {tag, " R6 locked"}, locked, m[126]);
        if (r) chk(rsp_vld && rsp_data == exp_rsp, {tag, " R8 R9 rsp"}, {rsp_vld, rsp_data}, {1'b1, exp_rsp});
        else   chk(!rsp_vld, {tag, " R8 idle"}, rsp_vld, 0);
    endtask

    initial begin
        #200000;
        total++; bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        do_reset();
        chk(b_fact_err == 1'b1, "R2 bad factory image", b_fact_err, 1);

        // R2 R3: a data bit makes customer parity odd, a read then returns zero (R8)
        step(1, 50, 1, 0, 0, 0, 1, 5, "set data");
        step(0, 0, 0, 0, 0, 0, 1, 5, "read during fault R8");
        // R9: fixing parity through the serial port clears the fault, zero sample maps to one
        step(0, 0, 0, 1, 127, 1, 0, 0, "fix parity");
        step(0, 0, 0, 0, 0, 0, 1, 0, "zero sample R9");
        chk(b_rsp_data == '0, "R8 factory fault forces zero", b_rsp_data, 0);
        // R3: value 0 on a blank bit is harmless
        step(1, 60, 0, 0, 0, 0, 0, 0, "clear blank R3");
        // R4: clearing a set bit is ignored, error sticks (R10)
        step(1, 50, 0, 0, 0, 0, 0, 0, "clear set R4");
        step(0, 0, 0, 1, 70, 1, 1, 9, "after err R10");

        do_reset();
        // R5: factory address rejected
        step(1, 10, 1, 0, 0, 0, 0, 0, "factory addr R5");

        do_reset();
        // R7: collision, bus wins, serial retries
        step(1, 60, 1, 1, 61, 1, 0, 0, "collide R7");
        step(0, 0, 0, 1, 61, 1, 0, 0, "serial retry R7");

        // random mix
        for (int i = 0; i < 400; i++) begin
            bit bv, sv, bval, sval, r;
            int ba, sa, s;
            bv = ($urandom % 3) == 0;  ba = 48 + ($urandom % 78); bval = ($urandom % 4) != 0;
            sv = ($urandom % 3) == 0;  sa = 48 + ($urandom % 78); sval = ($urandom % 4) != 0;
            r = $urandom % 2;
            s = (($urandom % 8) == 0) ? 0 : int'($urandom % 1024);
            step(bv, ba, bval, sv, sa, sval, r, s, "random");
        end

        do_reset();
        // R6: lock, then both ports are refused
        step(0, 0, 0, 1, 126, 1, 0, 0, "lock R6");
        step(1, 90, 1, 0, 0, 0, 0, 0, "locked bus R6");
        step(0, 0, 0, 1, 91, 1, 1, 33, "locked serial R6");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule